// File: doc/BRIEF.md
# Inter-processor Mailbox Channel Controller

This block is a memory-mapped message post office between a local processor and remote processors. It holds a set of independent channels. Each one carries a short, fixed message of eight 32-bit words together with a small control set. A sender first claims a channel for its own one-hot source vector. It then picks a one-hot destination vector, fills the message words and fires a send. The send raises the destination interrupt line. The channel then waits for an acknowledge, which is either produced automatically after a fixed delay or inferred when the receiver clears its pending status. The acknowledge pulses the interrupt line of the sender.

A global key register guards all channel state. Until the key value is written, writes into every channel window are dropped. Reads are still served while the key is not written. Each channel occupies a 64-byte window starting at channel × 0x40. Inside the window the register index is address bits [5:2]: indices 0–7 are control registers and 8–15 are the message words. The key register sits at byte address 0xA00. Read data is registered and appears in the cycle after a read strobe. The interrupt outputs are combinational functions of registered channel state.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the key register reads 1 (locked), every channel's mode register reads 0x10 (idle), every mask reads all ones, message words read 0, and dst_irq is 0. An asserted rst_n clears dst_irq at once.
- R2: Writing 0x1ACCE551 to 0xA00 makes it read 0. Writing any other value to 0xA00 makes it read 1 again from the next cycle.
- R3: While locked, a write to any channel register changes nothing that a later read or interrupt output shows.
- R4: Mode register bits are: bit0 auto-acknowledge, bit4 idle, bit5 ready, bit6 busy, bit7 acknowledged. Claiming a channel needs a write of a one-hot value to the source register (offset 0x00) while the channel is idle. After the claim, the source reads back that value and the mode shows ready. A nonzero write to the source register is ignored if the channel is not idle or if the value is not one-hot. Writing 0 releases the channel to idle and clears the source.
- R5: The eight message words at offsets 0x20 + 4·i (i = 0..7) read back what was last written to each of them.
- R6: A write to the send register (0x1C) with exactly the source value while ready moves the channel to busy and ORs the destination register (0x04) into the destination status (0x0C). A send write with any other value is ignored.
- R7: dst_irq[v] is high when some channel has status bit v set and mask (0x14) bit v clear. A mask bit of 1 suppresses the output while the status stays readable.
- R8: With auto-acknowledge set (mode write bit0 = 1), the channel enters the acknowledged state exactly ACK_DELAY cycles after the send edge. In that cycle ack_irq shows the source vector for exactly one cycle.
- R9: With auto-acknowledge clear, a busy channel stays busy until a write to destination-clear (0x08) leaves its status at zero. At that edge it enters the acknowledged state and pulses ack_irq with the source vector.
- R10: A write to destination-clear clears exactly the status bits that are 1 in the written value, and the matching dst_irq lines fall in the next cycle.
- R11: In the acknowledged state, writing the source value to interrupt-clear (0x18) returns the channel to ready. Any other value is ignored.
- R12: Channels are independent. Accesses to a channel index at or above NUM_CH write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; rdata updates at the same edge |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| dst_irq | output | NUM_VEC | Destination interrupt vector, masked |
| ack_irq | output | NUM_VEC | One-cycle acknowledge pulse to the source vector |

## Verification
A channel stuck in the wrong state shows in the mode register on the next read. It also shows in dst_irq or ack_irq in the cycle after the edge where it went wrong. An off-by-one in the acknowledge timer moves the ack_irq pulse by a cycle, so the bench samples every cycle of the window. A lock or mask decode error shows as a message word or source value that changed when it should not have, or as an interrupt line that is high while its mask bit is set. The bench reads these back at the ports right after the stimulus.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_READY = 2'd1,
    CH_BUSY  = 2'd2,
    CH_ACK   = 2'd3
  } ch_state_t;

  localparam logic [3:0] IDX_SRC   = 4'd0;
  localparam logic [3:0] IDX_DST   = 4'd1;
  localparam logic [3:0] IDX_DCLR  = 4'd2;
  localparam logic [3:0] IDX_DSTAT = 4'd3;
  localparam logic [3:0] IDX_MODE  = 4'd4;
  localparam logic [3:0] IDX_MASK  = 4'd5;
  localparam logic [3:0] IDX_ICLR  = 4'd6;
  localparam logic [3:0] IDX_SEND  = 4'd7;

  localparam int          MSG_WORDS  = 8;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/mbox_lock.sv
`timescale 1ns/1ps
module mbox_lock
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  output logic        locked
);
  logic locked_q, locked_d;

  always_comb begin
    locked_d = locked_q;
    if (wr_hit) locked_d = (wdata != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b1;
    else        locked_q <= locked_d;
  end

  assign locked = locked_q;
endmodule

// File: rtl/mbox_chan.sv
`timescale 1ns/1ps
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int NUM_VEC   = 8,
  parameter int ACK_DELAY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_idx,
  input  logic [31:0]        wdata,
  input  logic [3:0]         rd_idx,
  output logic [31:0]        rd_word,
  output logic [NUM_VEC-1:0] src_o,
  output logic [NUM_VEC-1:0] dstat_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic               ack_o,
  output ch_state_t          state_o
);
  localparam int CNT_W = (ACK_DELAY > 1) ? $clog2(ACK_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DELAY - 1);

  ch_state_t          state_q, state_d;
  logic [NUM_VEC-1:0] src_q, src_d;
  logic [NUM_VEC-1:0] dst_q, dst_d;
  logic [NUM_VEC-1:0] dstat_q, dstat_d;
  logic [NUM_VEC-1:0] mask_q, mask_d;
  logic               auto_q, auto_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ack_q, ack_d;
  logic [31:0]        msg_q [MSG_WORDS];
  logic [MSG_WORDS-1:0] msg_we;

  logic [NUM_VEC-1:0] wv;
  logic w_src, w_dst, w_dclr, w_mode, w_mask, w_iclr, w_send;
  logic wv_onehot;

  assign wv        = wdata[NUM_VEC-1:0];
  assign wv_onehot = (wv != '0) && ((wv & (wv - 1'b1)) == '0);
  assign w_src  = wr_en && (wr_idx == IDX_SRC);
  assign w_dst  = wr_en && (wr_idx == IDX_DST);
  assign w_dclr = wr_en && (wr_idx == IDX_DCLR);
  assign w_mode = wr_en && (wr_idx == IDX_MODE);
  assign w_mask = wr_en && (wr_idx == IDX_MASK);
  assign w_iclr = wr_en && (wr_idx == IDX_ICLR);
  assign w_send = wr_en && (wr_idx == IDX_SEND);

  always_comb begin
    for (int i = 0; i < MSG_WORDS; i++) begin
      msg_we[i] = wr_en && wr_idx[3] && (wr_idx[2:0] == 3'(i));
    end
  end

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    dstat_d = dstat_q;
    mask_d  = mask_q;
    auto_d  = auto_q;
    cnt_d   = cnt_q;
    ack_d   = 1'b0;

    if (w_dst)  dst_d  = wv;
    if (w_mask) mask_d = wv;
    if (w_mode) auto_d = wdata[0];
    if (w_dclr) dstat_d = dstat_q & ~wv;

    unique case (state_q)
      CH_IDLE: begin
        if (w_src && wv_onehot) begin
          src_d   = wv;
          state_d = CH_READY;
        end
      end
      CH_READY: begin
        if (w_send && (wv == src_q)) begin
          state_d = CH_BUSY;
          dstat_d = dstat_q | dst_q;
          cnt_d   = CNT_LOAD;
        end
      end
      CH_BUSY: begin
        if (auto_q) begin
          if (cnt_q == '0) begin
            state_d = CH_ACK;
            ack_d   = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end else if (w_dclr && (dstat_d == '0)) begin
          state_d = CH_ACK;
          ack_d   = 1'b1;
        end
      end
      CH_ACK: begin
        if (w_iclr && (wv == src_q)) state_d = CH_READY;
      end
      default: state_d = CH_IDLE;
    endcase

    // release has the last word in every state
    if (w_src && (wv == '0)) begin
      state_d = CH_IDLE;
      src_d   = '0;
      ack_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      dstat_q <= '0;
      mask_q  <= '1;
      auto_q  <= 1'b0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      dstat_q <= dstat_d;
      mask_q  <= mask_d;
      auto_q  <= auto_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_WORDS; i++) msg_q[i] <= '0;
    end else begin
      for (int i = 0; i < MSG_WORDS; i++) begin
        if (msg_we[i]) msg_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_idx[3]) begin
      rd_word = msg_q[rd_idx[2:0]];
    end else begin
      unique case (rd_idx)
        IDX_SRC:   rd_word = 32'(src_q);
        IDX_DST:   rd_word = 32'(dst_q);
        IDX_DSTAT: rd_word = 32'(dstat_q);
        IDX_MASK:  rd_word = 32'(mask_q);
        IDX_MODE:  rd_word = {24'd0,
                              state_q == CH_ACK, state_q == CH_BUSY,
                              state_q == CH_READY, state_q == CH_IDLE,
                              3'd0, auto_q};
        default:   rd_word = '0;
      endcase
    end
  end

  assign src_o   = src_q;
  assign dstat_o = dstat_q;
  assign mask_o  = mask_q;
  assign ack_o   = ack_q;
  assign state_o = state_q;
endmodule

// File: rtl/mbox_irq_merge.sv
`timescale 1ns/1ps
module mbox_irq_merge #(
  parameter int NUM_CH  = 4,
  parameter int NUM_VEC = 8
) (
  input  logic [NUM_CH-1:0][NUM_VEC-1:0] dstat,
  input  logic [NUM_CH-1:0][NUM_VEC-1:0] mask,
  input  logic [NUM_CH-1:0][NUM_VEC-1:0] src,
  input  logic [NUM_CH-1:0]              ack,
  output logic [NUM_VEC-1:0]             dst_irq,
  output logic [NUM_VEC-1:0]             ack_irq
);
  always_comb begin
    dst_irq = '0;
    ack_irq = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      dst_irq = dst_irq | (dstat[c] & ~mask[c]);
      ack_irq = ack_irq | (src[c] & {NUM_VEC{ack[c]}});
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_VEC   = 8,
  parameter int ACK_DELAY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [11:0]        addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_VEC-1:0] dst_irq,
  output logic [NUM_VEC-1:0] ack_irq
);
  localparam logic [11:0] LOCK_ADDR = 12'hA00;
  localparam logic [5:0]  CH_LIMIT  = 6'(NUM_CH);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic       lock_on;
  logic       lock_hit;
  logic [5:0] ch_idx;
  logic       ch_hit;

  assign lock_hit = (addr == LOCK_ADDR);
  assign ch_idx   = addr[11:6];
  assign ch_hit   = (ch_idx < CH_LIMIT);

  mbox_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_hit (wr_en && lock_hit),
    .wdata  (wdata),
    .locked (lock_on)
  );

  logic [NUM_CH-1:0][NUM_VEC-1:0] src_all, dstat_all, mask_all;
  logic [NUM_CH-1:0]              ack_all;
  logic [NUM_CH-1:0][1:0]         state_flat;
  logic [31:0]                    word_all [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_state_t st;
    mbox_chan #(
      .NUM_VEC   (NUM_VEC),
      .ACK_DELAY (ACK_DELAY)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en && !lock_on && (ch_idx == 6'(c))),
      .wr_idx  (addr[5:2]),
      .wdata   (wdata),
      .rd_idx  (addr[5:2]),
      .rd_word (word_all[c]),
      .src_o   (src_all[c]),
      .dstat_o (dstat_all[c]),
      .mask_o  (mask_all[c]),
      .ack_o   (ack_all[c]),
      .state_o (st)
    );
    assign state_flat[c] = st;
  end

  mbox_irq_merge #(
    .NUM_CH  (NUM_CH),
    .NUM_VEC (NUM_VEC)
  ) u_irq (
    .dstat   (dstat_all),
    .mask    (mask_all),
    .src     (src_all),
    .ack     (ack_all),
    .dst_irq (dst_irq),
    .ack_irq (ack_irq)
  );

  logic [31:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (lock_hit) begin
      rdata_d = {31'd0, lock_on};
    end else if (ch_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == 6'(c)) rdata_d = word_all[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_en)   rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ipc_mailbox_checker.sv
`timescale 1ns/1ps
module ipc_mailbox_checker #(
  parameter int NUM_CH  = 4,
  parameter int NUM_VEC = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [11:0]                       addr,
  input logic [31:0]                       wdata,
  input logic                              locked,
  input logic [NUM_CH-1:0][NUM_VEC-1:0]    src_all,
  input logic [NUM_CH-1:0][1:0]            state_all,
  input logic [NUM_CH-1:0]                 ack_all
);
  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'hA00 && wdata == 32'h1ACC_E551) |=> !locked);

  p_other_relocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'hA00 && wdata != 32'h1ACC_E551) |=> locked);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_locked_src_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en) |=> $stable(src_all[c]));

    p_owned_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_all[c] != 2'd0) |-> $onehot(src_all[c]));

    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_all[c] |=> !ack_all[c]);

    p_ack_in_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_all[c] |-> (state_all[c] == 2'd3));
  end
endmodule

bind ipc_mailbox ipc_mailbox_checker #(
  .NUM_CH  (NUM_CH),
  .NUM_VEC (NUM_VEC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .locked    (lock_on),
  .src_all   (src_all),
  .state_all (state_flat),
  .ack_all   (ack_all)
);

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
  localparam int NUM_CH    = 4;
  localparam int NUM_VEC   = 8;
  localparam int ACK_DELAY = 4;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [11:0]       addr  = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_VEC-1:0] dst_irq, ack_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox #(
    .NUM_CH    (NUM_CH),
    .NUM_VEC   (NUM_VEC),
    .ACK_DELAY (ACK_DELAY)
  ) u_ipc_mailbox (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .dst_irq (dst_irq),
    .ack_irq (ack_irq)
  );

  // {write, req, addr, wdata, expected}
  localparam int NV = 36;
  localparam logic [80:0] VEC [NV] = '{
    // R1 reset view
    {1'b0, 4'd1,  12'hA00, 32'h0, 32'h1},
    {1'b0, 4'd1,  12'h010, 32'h0, 32'h10},
    {1'b0, 4'd1,  12'h014, 32'h0, 32'hFF},
    {1'b0, 4'd1,  12'h04C, 32'h0, 32'h0},
    // R3 writes while locked
    {1'b1, 4'd3,  12'h020, 32'hDEAD0001, 32'h0},
    {1'b1, 4'd3,  12'h000, 32'h1, 32'h0},
    {1'b0, 4'd3,  12'h020, 32'h0, 32'h0},
    {1'b0, 4'd3,  12'h000, 32'h0, 32'h0},
    // R2 key
    {1'b1, 4'd2,  12'hA00, KEY, 32'h0},
    {1'b0, 4'd2,  12'hA00, 32'h0, 32'h0},
    // R4 claim, refused reclaim, non-one-hot claim
    {1'b1, 4'd4,  12'h000, 32'h4, 32'h0},
    {1'b0, 4'd4,  12'h000, 32'h0, 32'h4},
    {1'b0, 4'd4,  12'h010, 32'h0, 32'h20},
    {1'b1, 4'd4,  12'h000, 32'h8, 32'h0},
    {1'b0, 4'd4,  12'h000, 32'h0, 32'h4},
    {1'b1, 4'd4,  12'h040, 32'h6, 32'h0},
    {1'b0, 4'd4,  12'h050, 32'h0, 32'h10},
    {1'b0, 4'd4,  12'h040, 32'h0, 32'h0},
    // R5 message words
    {1'b1, 4'd5,  12'h020, 32'h11111111, 32'h0},
    {1'b1, 4'd5,  12'h03C, 32'h88888888, 32'h0},
    {1'b1, 4'd5,  12'h02C, 32'h55AA55AA, 32'h0},
    {1'b0, 4'd5,  12'h020, 32'h0, 32'h11111111},
    {1'b0, 4'd5,  12'h03C, 32'h0, 32'h88888888},
    {1'b0, 4'd5,  12'h02C, 32'h0, 32'h55AA55AA},
    // R12 channel independence and absent channel
    {1'b1, 4'd12, 12'h060, 32'hCAFEF00D, 32'h0},
    {1'b0, 4'd12, 12'h060, 32'h0, 32'hCAFEF00D},
    {1'b0, 4'd12, 12'h020, 32'h0, 32'h11111111},
    {1'b1, 4'd12, 12'h120, 32'h12345678, 32'h0},
    {1'b0, 4'd12, 12'h120, 32'h0, 32'h0},
    {1'b0, 4'd12, 12'h010, 32'h0, 32'h20},
    // R6 set up destination, mask, auto mode
    {1'b1, 4'd6,  12'h004, 32'h2, 32'h0},
    {1'b1, 4'd6,  12'h014, 32'hFD, 32'h0},
    {1'b1, 4'd6,  12'h010, 32'h1, 32'h0},
    {1'b0, 4'd6,  12'h010, 32'h0, 32'h21},
    {1'b1, 4'd6,  12'h01C, 32'h1, 32'h0},
    {1'b0, 4'd6,  12'h010, 32'h0, 32'h21}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    idle(4);
    check(1, 32'(dst_irq), 32'h0, "dst_irq in reset (R1)");
    rst_n = 1'b1;
    idle(4);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        wr(VEC[i][75:64], VEC[i][63:32]);
      end else begin
        rd(VEC[i][75:64], got);
        check(int'(VEC[i][79:76]), got, VEC[i][31:0], "vector read");
      end
    end

    // R8 auto acknowledge timing
    wr(12'h01C, 32'h4);
    check(7, 32'(dst_irq), 32'h2, "dst_irq after send (R7)");
    check(8, 32'(ack_irq), 32'h0, "no ack at send (R8)");
    for (int k = 1; k <= ACK_DELAY; k++) begin
      idle(1);
      check(8, 32'(ack_irq), (k == ACK_DELAY) ? 32'h4 : 32'h0, "ack pulse timing (R8)");
    end
    idle(1);
    check(8, 32'(ack_irq), 32'h0, "ack pulse one cycle (R8)");
    rd(12'h010, got); check(8, got, 32'h81, "mode acknowledged (R8)");
    rd(12'h00C, got); check(6, got, 32'h2, "status after send (R6)");

    // R10 destination clear
    wr(12'h008, 32'h2);
    check(10, 32'(dst_irq), 32'h0, "dst_irq after clear (R10)");
    rd(12'h00C, got); check(10, got, 32'h0, "status cleared (R10)");

    // R11 interrupt clear
    wr(12'h018, 32'h1);
    rd(12'h010, got); check(11, got, 32'h81, "wrong iclr ignored (R11)");
    wr(12'h018, 32'h4);
    rd(12'h010, got); check(11, got, 32'h21, "iclr back to ready (R11)");

    // R7 mask suppression
    wr(12'h014, 32'hFF);
    wr(12'h01C, 32'h4);
    check(7, 32'(dst_irq), 32'h0, "masked dst_irq (R7)");
    rd(12'h00C, got); check(7, got, 32'h2, "masked status visible (R7)");
    idle(ACK_DELAY + 1);
    rd(12'h010, got); check(8, got, 32'h81, "masked send acknowledged (R8)");
    wr(12'h008, 32'h2);
    wr(12'h018, 32'h4);

    // R9 manual acknowledge with two destinations
    wr(12'h010, 32'h0);
    rd(12'h010, got); check(9, got, 32'h20, "manual mode ready (R9)");
    wr(12'h004, 32'h6);
    wr(12'h014, 32'hF9);
    wr(12'h01C, 32'h4);
    check(7, 32'(dst_irq), 32'h6, "two destination lines (R7)");
    rd(12'h010, got); check(6, got, 32'h40, "busy after send (R6)");
    idle(10);
    rd(12'h010, got); check(9, got, 32'h40, "manual stays busy (R9)");
    wr(12'h008, 32'h2);
    check(10, 32'(dst_irq), 32'h4, "partial clear (R10)");
    check(9, 32'(ack_irq), 32'h0, "no ack on partial clear (R9)");
    wr(12'h008, 32'h4);
    check(9, 32'(ack_irq), 32'h4, "ack on last clear (R9)");
    rd(12'h010, got); check(9, got, 32'h80, "manual acknowledged (R9)");

    // R4 release
    wr(12'h018, 32'h4);
    wr(12'h000, 32'h0);
    rd(12'h010, got); check(4, got, 32'h10, "released to idle (R4)");
    rd(12'h000, got); check(4, got, 32'h0, "source cleared (R4)");

    // R2 relock, R3 locked claim
    wr(12'hA00, 32'h0);
    rd(12'hA00, got); check(2, got, 32'h1, "relocked (R2)");
    wr(12'h000, 32'h1);
    rd(12'h000, got); check(3, got, 32'h0, "locked claim ignored (R3)");
    rd(12'h010, got); check(3, got, 32'h10, "locked channel idle (R3)");

    // R1 reset in the middle of a transfer
    wr(12'hA00, KEY);
    wr(12'h000, 32'h2);
    wr(12'h004, 32'h1);
    wr(12'h014, 32'hFE);
    wr(12'h01C, 32'h2);
    check(7, 32'(dst_irq), 32'h1, "dst_irq before reset (R7)");
    rst_n = 1'b0;
    #1;
    check(1, 32'(dst_irq), 32'h0, "dst_irq cleared by reset (R1)");
    idle(2);
    rst_n = 1'b1;
    idle(4);
    rd(12'hA00, got); check(1, got, 32'h1, "locked after reset (R1)");
    rd(12'h010, got); check(1, got, 32'h10, "idle after reset (R1)");
    rd(12'h020, got); check(1, got, 32'h0, "message cleared (R1)");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule